// File: doc/BRIEF.md
# Bus interface power-down controller

This block decides when the host-side bus interface of a peripheral controller is powered down. It watches an active-low power-down pin and an active-low bus reset pin, synchronises both into the local clock domain, and drives an active-low reset that holds the interface logic idle while any shutdown condition is present. A local processor reaches a single control register through a small strobe-based port.

Two shutdown modes exist. In the register-driven mode, software sets a bit and the interface stays down until software clears that bit or a bus reset occurs. In the pin-driven mode, software first arms an enable bit. From then on the interface goes down on the same clock in which the synchronised power-down level falls. A later rising edge of the pin releases the interface and disarms the enable bit by itself. Arming the pin-driven mode also drops the register-driven bit, so software can hand one mode over to the other without a gap. Every falling edge of the pin records a sticky status flag, which can raise an interrupt.

Top module: `pdn_ctrl`

## Requirements
- R1: After the system reset, with both pins high: mode reads 00, ifRstN is 1, irq is 0, and the control register reads 0x00.
- R2: The control register is at address 0. Bit 0 is swDown, bit 1 is hwArm, bit 2 is irqEn and bit 3 is the status flag. Bits 7..4 read as 0. A read at any other address returns 0x00, and a write to any other address changes nothing.
- R3: Writing swDown=1 puts the block in software shutdown from the next clock: mode 01 and ifRstN 0. Writing swDown=0 returns the block to mode 00 with ifRstN 1.
- R4: A rising edge on the power-down pin leaves software shutdown and swDown unchanged.
- R5: With hwArm=1, mode becomes 10 and ifRstN becomes 0 in the same clock in which the two-stage synchronised pin level falls. After the pin falls, the mode is still 00 at one clock and is 10 at two clocks.
- R6: A register write with bit 1 set clears swDown, whatever value bit 0 carries in that write.
- R7: A rising edge of the synchronised pin ends hardware shutdown (mode 00, ifRstN 1) and clears hwArm to 0.
- R8: A falling edge of the synchronised pin sets the status flag. irq is 1 exactly while both the flag and irqEn are 1.
- R9: Writing 1 to bit 3 clears the status flag. Writing 0 to bit 3 leaves the flag unchanged.
- R10: While the synchronised bus reset is low: ifRstN is 0, and the flag and swDown are held at 0. hwArm keeps its value, and hardware shutdown persists while the pin is low.
- R11: Register writes have no effect while mode is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| pdPinN | input | 1 | Power-down pin, active low, asynchronous |
| busPinN | input | 1 | Bus reset pin, active low, asynchronous |
| regWr | input | 1 | One-cycle register write strobe |
| regAddr | input | ADDR_W | Register address for reads and writes |
| regWData | input | DATA_W | Write data |
| regRData | output | DATA_W | Read data, combinational from regAddr |
| ifRstN | output | 1 | Reset to the interface logic, active low |
| irq | output | 1 | Shutdown/error interrupt |
| mode | output | 2 | 00 active, 01 software shutdown, 10 hardware shutdown |

## Verification
The hardest state to reach is the boundary between the two shutdown modes. Covering it means entering software shutdown, toggling the pin underneath it, arming the pin mode with a write that also carries swDown=1, and then dropping the pin. The stimulus checks the mode one clock and two clocks after the pin falls, so the same-clock entry is pinned to the synchroniser depth. It then stays in hardware shutdown long enough to try writes and a bus reset before the rising edge releases it.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  localparam int SW_BIT    = 0;
  localparam int HWARM_BIT = 1;
  localparam int IRQEN_BIT = 2;
  localparam int FLAG_BIT  = 3;
  localparam int CTRL_BITS = 4;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SW     = 2'b01,
    MODE_HW     = 2'b10
  } mode_e;

  typedef struct packed {
    logic wrCtrl;
    logic clrSw;
    logic clrHwArm;
    logic setFlag;
    logic clrFlag;
    logic busRst;
  } strobe_t;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], asyncIn[gi]};
      end
      assign syncOut[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pdn_control.sv
module pdn_control
  import pdn_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdSync,
  input  logic              brSync,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  logic              hwArm,
  input  logic              swDown,
  output strobe_t           strb,
  output mode_e             modeNow,
  output logic              ifRstN
);
  logic pdPrev;
  logic pdFall;
  logic pdRise;
  logic hwDown;
  logic wrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdPrev <= 1'b1;
    else       pdPrev <= pdSync;
  end

  assign pdFall = pdPrev & ~pdSync;
  assign pdRise = ~pdPrev & pdSync;
  assign hwDown = hwArm & ~pdSync;
  assign wrHit  = regWr && (regAddr == ADDR_W'(CTRL_ADDR)) && !hwDown;

  always_comb begin
    strb          = '0;
    strb.wrCtrl   = wrHit;
    strb.busRst   = ~brSync;
    strb.clrSw    = wrHit & regWData[HWARM_BIT];
    strb.clrHwArm = pdRise;
    strb.setFlag  = pdFall;
    strb.clrFlag  = wrHit & regWData[FLAG_BIT];
  end

  always_comb begin
    if (hwDown)      modeNow = MODE_HW;
    else if (swDown) modeNow = MODE_SW;
    else             modeNow = MODE_ACTIVE;
  end

  assign ifRstN = brSync && (modeNow == MODE_ACTIVE);
endmodule

// File: rtl/pdn_regs.sv
module pdn_regs
  import pdn_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData,
  output logic              swDown,
  output logic              hwArm,
  output logic              irqEn,
  output logic              flag,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CTRL_BITS;

  logic [CTRL_BITS-1:0] ctrlVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swDown <= 1'b0;
      hwArm  <= 1'b0;
      irqEn  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (strb.wrCtrl) irqEn <= wData[IRQEN_BIT];

      if (strb.clrHwArm)    hwArm <= 1'b0;
      else if (strb.wrCtrl) hwArm <= wData[HWARM_BIT];

      if (strb.busRst || strb.clrSw) swDown <= 1'b0;
      else if (strb.wrCtrl)          swDown <= wData[SW_BIT];

      if (strb.busRst)       flag <= 1'b0;
      else if (strb.setFlag) flag <= 1'b1;
      else if (strb.clrFlag) flag <= 1'b0;
    end
  end

  always_comb begin
    ctrlVec            = '0;
    ctrlVec[SW_BIT]    = swDown;
    ctrlVec[HWARM_BIT] = hwArm;
    ctrlVec[IRQEN_BIT] = irqEn;
    ctrlVec[FLAG_BIT]  = flag;
  end

  generate
    if (PAD_W > 0) begin : gPad
      assign rData = (rAddr == ADDR_W'(CTRL_ADDR)) ? {{PAD_W{1'b0}}, ctrlVec} : '0;
    end else begin : gNoPad
      assign rData = (rAddr == ADDR_W'(CTRL_ADDR)) ? ctrlVec : '0;
    end
  endgenerate

  assign irq = flag & irqEn;
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int CTRL_ADDR   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdPinN,
  input  logic              busPinN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWData,
  output logic [DATA_W-1:0] regRData,
  output logic              ifRstN,
  output logic              irq,
  output logic [1:0]        mode
);
  logic [1:0] syncLv;
  logic       pdSync;
  logic       brSync;
  strobe_t    strb;
  mode_e      modeNow;
  logic       swDown;
  logic       hwArm;
  logic       irqEn;
  logic       flag;

  pdn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({busPinN, pdPinN}), .syncOut(syncLv)
  );
  assign pdSync = syncLv[0];
  assign brSync = syncLv[1];

  pdn_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .pdSync(pdSync), .brSync(brSync),
    .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .hwArm(hwArm), .swDown(swDown), .strb(strb), .modeNow(modeNow),
    .ifRstN(ifRstN)
  );

  pdn_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(regWData), .rAddr(regAddr),
    .rData(regRData), .swDown(swDown), .hwArm(hwArm), .irqEn(irqEn),
    .flag(flag), .irq(irq)
  );

  assign mode = modeNow;
endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pdSync,
  input logic       brSync,
  input logic       hwArm,
  input logic       swDown,
  input logic       flag,
  input logic       irq,
  input logic       ifRstN,
  input logic [1:0] mode
);
  AST_HW_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (hwArm && !pdSync) |-> (mode == 2'b10)) else $error("hw entry");      // R5
  AST_DOWN_HOLDS_RST: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |-> !ifRstN) else $error("shutdown without reset");   // R3
  AST_RISE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdSync) |=> !hwArm) else $error("arm kept after rise");         // R7
  AST_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pdSync) && brSync) |=> flag) else $error("flag not set");      // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag) else $error("irq without flag");                        // R8
  AST_BUSRST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !brSync |-> !ifRstN) else $error("bus reset not propagated");         // R10
  AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!brSync && !$past(brSync)) |-> (!flag && !swDown)) else $error("bus reset clear"); // R10
  AST_RISE_KEEPS_SW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pdSync) && $past(swDown) && brSync && $past(brSync)) |-> swDown)
    else $error("rise released sw");                                      // R4
endmodule

bind pdn_ctrl pdn_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .pdSync(pdSync), .brSync(brSync), .hwArm(hwArm),
  .swDown(swDown), .flag(flag), .irq(irq), .ifRstN(ifRstN), .mode(mode)
);

// File: tb/pdn_ctrl_test.sv
module pdn_ctrl_test;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pdPinN = 1'b1;
  logic              busPinN = 1'b1;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWData = '0;
  logic [DATA_W-1:0] regRData;
  logic              ifRstN;
  logic              irq;
  logic [1:0]        mode;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] m;
    logic       rs;
    logic       iq;
    logic [7:0] rd;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  pdn_ctrl uut (
    .clk(clk), .rstN(rstN), .pdPinN(pdPinN), .busPinN(busPinN),
    .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .ifRstN(ifRstN), .irq(irq), .mode(mode)
  );

  task automatic chk(input string tag, input logic [1:0] m, input logic rs,
                     input logic iq, input logic [7:0] rd, input logic [1:0] ra = 2'd0);
    exp_t e;
    regAddr = ra;
    e.tag = tag; e.m = m; e.rs = rs; e.iq = iq; e.rd = rd;
    expQ.push_back(e);
    wait (expQ.size() == 0);
    #1;
    regAddr = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = '0; regWData = '0;
  endtask

  task automatic setPd(input logic v, input int waitCyc);
    @(negedge clk);
    pdPinN = v;
    repeat (waitCyc) @(negedge clk);
  endtask

  task automatic setBus(input logic v);
    @(negedge clk);
    busPinN = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (expQ.size() > 0);
      @(negedge clk);
      e = expQ[0];
      compared++;
      if (mode !== e.m || ifRstN !== e.rs || irq !== e.iq || regRData !== e.rd) begin
        mismatched++;
        $display("FAIL %s: got mode=%b ifRstN=%b irq=%b rd=%h, expected mode=%b ifRstN=%b irq=%b rd=%h",
                 e.tag, mode, ifRstN, irq, regRData, e.m, e.rs, e.iq, e.rd);
      end
      void'(expQ.pop_front());
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 2'b00, 1'b1, 1'b0, 8'h00);

    wr(2'd0, 8'h04);
    chk("R2 irqEn readback", 2'b00, 1'b1, 1'b0, 8'h04);
    wr(2'd1, 8'h01);
    chk("R2 write elsewhere ignored", 2'b00, 1'b1, 1'b0, 8'h04);
    chk("R2 read elsewhere zero", 2'b00, 1'b1, 1'b0, 8'h00, 2'd1);

    wr(2'd0, 8'h05);
    chk("R3 sw shutdown", 2'b01, 1'b0, 1'b0, 8'h05);
    setPd(1'b0, 4);
    chk("R8 fall sets flag in sw mode", 2'b01, 1'b0, 1'b1, 8'h0D);
    setPd(1'b1, 4);
    chk("R4 rise keeps sw shutdown", 2'b01, 1'b0, 1'b1, 8'h0D);

    wr(2'd0, 8'h05);
    chk("R9 write 0 keeps flag", 2'b01, 1'b0, 1'b1, 8'h0D);
    wr(2'd0, 8'h0D);
    chk("R9 write 1 clears flag", 2'b01, 1'b0, 1'b0, 8'h05);
    wr(2'd0, 8'h04);
    chk("R3 sw release", 2'b00, 1'b1, 1'b0, 8'h04);

    wr(2'd0, 8'h05);
    wr(2'd0, 8'h07);
    chk("R6 arming clears swDown", 2'b00, 1'b1, 1'b0, 8'h06);

    setPd(1'b0, 0);
    chk("R5 one clock after fall", 2'b00, 1'b1, 1'b0, 8'h06);
    chk("R5 two clocks after fall", 2'b10, 1'b0, 1'b0, 8'h06);
    chk("R8 flag and irq in hw mode", 2'b10, 1'b0, 1'b1, 8'h0E);

    wr(2'd0, 8'h01);
    wr(2'd0, 8'h08);
    chk("R11 writes ignored in hw mode", 2'b10, 1'b0, 1'b1, 8'h0E);

    setBus(1'b0);
    chk("R10 bus reset keeps arm", 2'b10, 1'b0, 1'b0, 8'h06);
    setBus(1'b1);
    chk("R10 hw persists after bus reset", 2'b10, 1'b0, 1'b0, 8'h06);

    setPd(1'b1, 4);
    chk("R7 rise releases and disarms", 2'b00, 1'b1, 1'b0, 8'h04);

    wr(2'd0, 8'h01);
    chk("R3 sw again", 2'b01, 1'b0, 1'b0, 8'h01);
    setBus(1'b0);
    chk("R10 bus reset clears swDown", 2'b00, 1'b0, 1'b0, 8'h00);
    setBus(1'b1);
    chk("R10 active after bus reset", 2'b00, 1'b1, 1'b0, 8'h00);

    setPd(1'b0, 4);
    chk("R8 flag without irqEn", 2'b00, 1'b1, 1'b0, 8'h08);
    wr(2'd0, 8'h04);
    chk("R8 irq when enabled", 2'b00, 1'b1, 1'b1, 8'h0C);
    setPd(1'b1, 4);
    chk("R7 rise when unarmed", 2'b00, 1'b1, 1'b1, 8'h0C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule